// File: doc/BRIEF.md
# Programmable Clock Divider with Phase Offset

This block divides a fast input clock by any integer from 1 to 32 and delays the divided clock by a whole number of input periods. An odd ratio still yields a 50% duty cycle: the output high time is stretched by half an input period, and the falling edge lands on the falling edge of the input clock. A cascade option multiplies two ratios, so the total ratio is the product of two codes.

Each output channel gets its own instance. A single-cycle restart pulse loads the new ratio, offset and cascade choice, and it restarts the count from a known point. Several instances that receive the same restart pulse therefore produce aligned outputs, each one shifted by its own offset. A ratio of 1 routes the input clock straight to the output. The switch to that path happens only while the input clock is low. A lock flag shows when the output is running.

Top module: `clkdiv_phase`

## Requirements
- R1: Reset forces clk_out and locked low. Both stay low until the first sync pulse, whatever the other inputs do.
- R2: A ratio code c selects division by N = c+1, so code 0 gives 1 and code 31 gives 32. Once running, clk_out repeats every N rising edges of clk_in.
- R3: For even N, clk_out goes high on a rising clk_in edge and stays high for N/2 input periods, then low for N/2.
- R4: For odd N of 3 or more, clk_out goes high on a rising clk_in edge and stays high for (N-1)/2 periods plus one half period. It falls on a falling clk_in edge.
- R5: With a total ratio of 1, clk_out equals clk_in from the falling clk_in edge after the sync edge. The phase input has no effect.
- R6: Let k be the rising clk_in edge where sync is sampled high. The first rising clk_out edge occurs at rising edge k+(phase mod N)+1. clk_out is low from the falling edge after k until that point.
- R7: The ratio, phase and cascade inputs are sampled only on the edge where sync is high. Changes to them at any other time leave clk_out and locked unchanged.
- R8: If cascade_en is high at the sync edge, the total ratio is (ratio_a+1)×(ratio_b+1), from 1 to 1024. The phase and duty rules of R3 to R6 apply to this product.
- R9: locked goes low on the sync edge. It rises on the same rising clk_in edge as the first clk_out rise. It then stays high until the next sync pulse or reset.
- R10: A sync pulse while the block is running restarts the output from that edge under the new settings. This holds in every mode, including a change into or out of the ratio-1 pass-through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Single-cycle restart pulse that loads the settings |
| cascade_en | input | 1 | Selects the product ratio of both codes |
| ratio_a | input | 5 | First ratio code, N = code+1 |
| ratio_b | input | 5 | Second ratio code, used only in cascade mode |
| phase | input | 5 | Start delay in whole input periods, taken modulo the ratio |
| clk_out | output | 1 | Divided clock |
| locked | output | 1 | High while the divided clock is running |

## Verification
The first rising edge of clk_out is due (phase mod N)+1 rising edges after the sync edge. Each later output level follows from that edge, counted in half periods of the input clock. locked changes on the same rising edge as the output. The bench samples clk_out and locked 1 ns after every rising edge and again 1 ns after every falling edge. It compares each sample with a model that counts rising edges from the sync edge. The half period directly after the sync edge still carries the level left over from the old settings, so the bench skips that one output sample. Every half period after it is checked, including the low half in which the pass-through takes over.

// File: rtl/clkdiv_phase.sv
`timescale 1ns/1ps
module clkdiv_phase #(
  parameter int CODE_W = 5
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              cascade_en,
  input  logic [CODE_W-1:0] ratio_a,
  input  logic [CODE_W-1:0] ratio_b,
  input  logic [CODE_W-1:0] phase,
  output logic              clk_out,
  output logic              locked
);
  localparam int NW = CODE_W + 1;
  localparam int MW = 2 * CODE_W + 1;

  typedef enum logic [1:0] {IDLE, WAIT, RUN} st_t;
  st_t st;

  logic [NW-1:0] na, nb;
  logic [MW-1:0] m_in, off_in, load_in;
  logic [MW-1:0] m_r, cnt_r, inc, half;
  logic          q_r, qn_r, sel_r;

  assign na      = NW'(ratio_a) + NW'(1);
  assign nb      = NW'(ratio_b) + NW'(1);
  assign m_in    = cascade_en ? MW'(na) * MW'(nb) : MW'(na);
  assign off_in  = MW'(phase) % m_in;
  assign load_in = m_in - off_in - MW'(1);

  assign inc  = (cnt_r == m_r - MW'(1)) ? '0 : cnt_r + MW'(1);
  assign half = m_r >> 1;

  assign locked  = (st == RUN);
  assign clk_out = sel_r ? clk_in : (q_r | qn_r);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      m_r   <= MW'(1);
      cnt_r <= '0;
      q_r   <= 1'b0;
    end else if (sync) begin
      st    <= WAIT;
      m_r   <= m_in;
      cnt_r <= load_in;
      q_r   <= 1'b0;
    end else if (st != IDLE) begin
      cnt_r <= inc;
      if (st == RUN || inc == '0) begin
        st  <= RUN;
        q_r <= (inc < half);
      end
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      qn_r  <= 1'b0;
      sel_r <= 1'b0;
    end else begin
      qn_r  <= q_r & m_r[0];
      sel_r <= (m_r == MW'(1)) && (st != IDLE);
    end
  end
endmodule

// File: rtl/clkdiv_phase_chk.sv
`timescale 1ns/1ps
module clkdiv_phase_chk #(
  parameter int MW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync,
  input logic          locked,
  input logic          q,
  input logic [MW-1:0] cnt,
  input logic [MW-1:0] m
);
  AST_LOCK_CLEARED_BY_SYNC: assert property (@(posedge clk) disable iff (!rst_n) sync |=> !locked); // R9
  AST_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n) (locked && !sync) |=> locked); // R9
  AST_QUIET_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) !locked |-> !q); // R6
  AST_CNT_BELOW_RATIO: assert property (@(posedge clk) disable iff (!rst_n) cnt < m); // R2
  AST_RISE_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(q) |-> cnt == '0); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n) !sync |=> $stable(m)); // R7
endmodule

bind clkdiv_phase clkdiv_phase_chk #(.MW(MW)) u_chk (
  .clk(clk_in), .rst_n(rst_n), .sync(sync), .locked(locked),
  .q(q_r), .cnt(cnt_r), .m(m_r)
);

// File: tb/clkdiv_phase_bench.sv
`timescale 1ns/1ps
module clkdiv_phase_bench;
  logic clk_in = 1'b0, rst_n = 1'b0, sync = 1'b0, cascade_en = 1'b0;
  logic [4:0] ratio_a = '0, ratio_b = '0, phase = '0;
  logic clk_out, locked;

  int checks = 0, errors = 0;
  bit synced = 0, casc_e = 0, run_e, byp_e, e_hi, e_lo;
  int t = 0, m_e = 1, off_e = 0, h, ph;
  string scen = "";

  always #2 clk_in = ~clk_in;

  clkdiv_phase u_clkdiv_phase (
    .clk_in(clk_in), .rst_n(rst_n), .sync(sync), .cascade_en(cascade_en),
    .ratio_a(ratio_a), .ratio_b(ratio_b), .phase(phase),
    .clk_out(clk_out), .locked(locked)
  );

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", tag, what, $time, act, exp);
    end
  endtask

  function automatic string out_tag();
    if (!synced) return "R1";
    if (scen != "") return scen;
    if (byp_e) return "R5";
    if (!run_e) return "R6";
    if (casc_e) return "R8";
    if (m_e % 2 == 1) return "R2 R4";
    return "R2 R3";
  endfunction

  function automatic string lock_tag();
    if (!synced) return "R1";
    if (scen != "") return scen;
    return "R9";
  endfunction

  always @(posedge clk_in) begin
    if (!rst_n) synced = 0;
    else if (sync) begin
      m_e = cascade_en ? (int'(ratio_a) + 1) * (int'(ratio_b) + 1) : int'(ratio_a) + 1;
      off_e = int'(phase) % m_e;
      casc_e = cascade_en;
      t = 0;
      synced = 1;
    end else if (synced) t++;
    h = m_e / 2;
    run_e = synced && (t >= off_e + 1);
    ph = run_e ? (t - off_e - 1) % m_e : 0;
    byp_e = synced && (m_e == 1);
    e_hi = byp_e ? 1'b1 : (run_e && (ph < h || (m_e % 2 == 1 && ph == h)));
    e_lo = byp_e ? 1'b0 : (run_e && ph < h);
    #1;
    if (!(synced && t == 0)) chk(clk_out, e_hi, out_tag(), "clk_out in high half");
    chk(locked, run_e, lock_tag(), "locked after rising edge");
    @(negedge clk_in);
    #1;
    chk(clk_out, e_lo, out_tag(), "clk_out in low half");
    chk(locked, run_e, lock_tag(), "locked after falling edge");
  end

  task automatic go(input bit c, input logic [4:0] a, input logic [4:0] b,
                    input logic [4:0] p, input int cyc);
    @(negedge clk_in);
    cascade_en = c; ratio_a = a; ratio_b = b; phase = p; sync = 1'b1;
    @(negedge clk_in);
    sync = 1'b0;
    repeat (cyc) @(negedge clk_in);
  endtask

  initial begin
    int offs[4] = '{0, 3, 17, 31};
    repeat (4) @(negedge clk_in);
    rst_n = 1'b1;
    ratio_a = 5'd3; phase = 5'd2;
    repeat (10) @(negedge clk_in);

    for (int n = 1; n <= 32; n++)
      for (int k = 0; k < 4; k++)
        go(1'b0, 5'(n - 1), 5'd0, 5'(offs[k]), offs[k] % n + 1 + 3 * n + 2);

    go(1'b1, 5'd2, 5'd4, 5'd5, 60);
    go(1'b1, 5'd3, 5'd7, 5'd31, 140);
    go(1'b1, 5'd6, 5'd8, 5'd9, 200);
    go(1'b1, 5'd0, 5'd6, 5'd4, 30);
    go(1'b1, 5'd1, 5'd0, 5'd1, 12);
    go(1'b1, 5'd0, 5'd0, 5'd7, 10);
    go(1'b1, 5'd31, 5'd31, 5'd9, 2100);

    scen = "R10";
    go(1'b0, 5'd6, 5'd0, 5'd2, 10);
    go(1'b0, 5'd9, 5'd0, 5'd4, 7);
    go(1'b0, 5'd0, 5'd0, 5'd0, 5);
    go(1'b0, 5'd4, 5'd0, 5'd1, 20);
    go(1'b0, 5'd2, 5'd0, 5'd0, 4);
    go(1'b0, 5'd0, 5'd0, 5'd3, 6);

    scen = "R7";
    go(1'b0, 5'd8, 5'd0, 5'd1, 0);
    for (int i = 0; i < 80; i++) begin
      ratio_a = 5'(i * 7); ratio_b = 5'(i * 5); phase = 5'(i * 3); cascade_en = i[0];
      @(negedge clk_in);
    end
    scen = "";

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_in);
    checks++;
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule